// File: doc/BRIEF.md
# CAN Error Status Latch

This block sits between a CAN controller's frame engine and the software-visible status register. Each message center reports the errors it detected in the last frame as a one-hot strobe per error kind, and the controller reports clean frame ends and successful transmissions as single-cycle strobes. The latch condenses those strobes into a 3-bit error code and a transmit-success flag, and it raises a sticky status-change interrupt request.

The error code keeps the first error recorded after a read. Later errors are dropped until software reads the status, and a read normally returns the code to 111b, the "nothing new" value. When several kinds arrive in one cycle, possibly from different centers, one fixed ranking picks the code, and this ranking does not follow the numeric order of the codes. Software may also write the transmit-success flag, and a write that turns it from 0 to 1 produces an artificial status-change interrupt.

All outputs are registered. The effect of a strobe is visible one clock after the edge that samples it.

Top module: `can_errstat_latch`

## Requirements
- R1: While reset is high, and on the first clock after it, err_code_o is 111b, txs_o is 0 and irq_o is 0.
- R2: Error codes are 000 clean frame, 001 bit stuff, 010 format, 011 no acknowledge, 100 bit-1, 101 bit-0, 110 CRC and 111 no change since the last read. Center c reports kind k on err_flags_i bit c*6+k, where k is 0 stuff, 1 format, 2 no-ack, 3 bit-1, 4 bit-0 and 5 CRC. When err_code_o holds 000b or 111b, a strobe loads the matching code.
- R3: Kinds that arrive in the same cycle, from any mix of centers, resolve in this order, highest first: bit-0, stuff, CRC, no-ack, format, bit-1.
- R4: While err_code_o holds any code other than 000b or 111b, new error strobes are discarded. The code stays as it is and no interrupt is raised.
- R5: A pulse on stat_rd_i sets err_code_o to 111b when swint_mode_i is 0. When swint_mode_i is 1, the read leaves the code unchanged.
- R6: frame_clean_i loads 000b only when the code is 111b and no error strobe is present. It raises no interrupt.
- R7: Recording an error sets irq_o when err_ie_i is 1. When err_ie_i is 0, recording an error leaves irq_o unchanged.
- R8: tx_ok_i sets txs_o. When stat_ie_i is 1 it also sets irq_o, whether or not txs_o was already 1.
- R9: A write with txs_wr_en_i loads txs_wr_data_i into txs_o. A write that changes txs_o from 0 to 1 sets irq_o if stat_ie_i is 1. Writing 1 while txs_o is 1 raises nothing. tx_ok_i overrides a write of 0.
- R10: irq_o stays set until a stat_rd_i pulse clears it. A qualifying set event in the same cycle as the read wins over the clear.
- R11: Events in the same cycle as a read are judged against the code held before the read, and they take precedence over the read's clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| err_flags_i | input | NUM_CTR*6 | Per-center one-hot error kind strobes |
| frame_clean_i | input | 1 | Frame ended without error |
| tx_ok_i | input | 1 | Transmission succeeded |
| stat_rd_i | input | 1 | Status register read pulse |
| swint_mode_i | input | 1 | Read does not clear the error code |
| txs_wr_en_i | input | 1 | Software write of the transmit-success flag |
| txs_wr_data_i | input | 1 | Value written to the transmit-success flag |
| err_ie_i | input | 1 | Enable interrupt on a recorded error |
| stat_ie_i | input | 1 | Enable interrupt on transmit status events |
| err_code_o | output | 3 | Latched error code |
| txs_o | output | 1 | Transmit-success flag |
| irq_o | output | 1 | Sticky status-change interrupt request |

## Verification
Single strobes from one center establish the code mapping. Mixed strobes spread over several centers check that the ranking ignores which center reported each kind, and that it ignores the numeric code values. Strobes that arrive while a code is pending, clean-frame strobes against both 111b and a pending code, and reads with and without the software-interrupt mode separate the hold rule from the clear rule. Transmit and software-write cases cover a set when the flag is already set, a redundant write and a write of 0 racing a transmit. Reads that coincide with errors, clean frames and transmits check which action wins when both fall in the same cycle.

// File: rtl/can_errstat_pkg.sv
`timescale 1ns/1ps
package can_errstat_pkg;

    localparam int KIND_CNT   = 6;
    localparam int KIND_STUFF = 0;
    localparam int KIND_FORM  = 1;
    localparam int KIND_NOACK = 2;
    localparam int KIND_BIT1  = 3;
    localparam int KIND_BIT0  = 4;
    localparam int KIND_CRC   = 5;

    typedef enum logic [2:0] {
        ERR_NONE  = 3'b000,
        ERR_STUFF = 3'b001,
        ERR_FORM  = 3'b010,
        ERR_NOACK = 3'b011,
        ERR_BIT1  = 3'b100,
        ERR_BIT0  = 3'b101,
        ERR_CRC   = 3'b110,
        ERR_IDLE  = 3'b111
    } err_code_e;

    typedef struct packed {
        logic      hit;
        err_code_e code;
    } err_evt_t;

    // Map a strobe position to its code.
    function automatic err_code_e kind_to_code(logic [2:0] k);
        case (k)
            3'd0:    return ERR_STUFF;
            3'd1:    return ERR_FORM;
            3'd2:    return ERR_NOACK;
            3'd3:    return ERR_BIT1;
            3'd4:    return ERR_BIT0;
            3'd5:    return ERR_CRC;
            default: return ERR_IDLE;
        endcase
    endfunction

    // Strobe position holding priority rank r (0 = highest).
    function automatic logic [2:0] kind_at_rank(logic [2:0] r);
        case (r)
            3'd0:    return 3'(KIND_BIT0);
            3'd1:    return 3'(KIND_STUFF);
            3'd2:    return 3'(KIND_CRC);
            3'd3:    return 3'(KIND_NOACK);
            3'd4:    return 3'(KIND_FORM);
            default: return 3'(KIND_BIT1);
        endcase
    endfunction

    // Field accepts a new error only in these two states.
    function automatic logic is_open(err_code_e c);
        return (c == ERR_NONE) || (c == ERR_IDLE);
    endfunction

endpackage

// File: rtl/can_err_prio_sel.sv
`timescale 1ns/1ps
module can_err_prio_sel
    import can_errstat_pkg::*;
#(
    parameter int NUM_CTR = 3
) (
    input  logic                        clk_i,
    input  logic                        rst_i,
    input  logic [NUM_CTR*KIND_CNT-1:0] flags_i,
    output err_evt_t                    evt_o
);

    localparam int FLAG_W = NUM_CTR * KIND_CNT;

    logic [KIND_CNT-1:0][NUM_CTR-1:0] column;
    logic [KIND_CNT-1:0]              kind_any;

    // Gather each kind across all centers, then OR it down.
    for (genvar k = 0; k < KIND_CNT; k++) begin : g_kind
        for (genvar c = 0; c < NUM_CTR; c++) begin : g_ctr
            assign column[k][c] = flags_i[c*KIND_CNT + k];
        end
        assign kind_any[k] = |column[k];
    end

    // Walk from lowest rank to highest so the highest match is kept.
    always_comb begin
        evt_o.hit  = |kind_any;
        evt_o.code = ERR_IDLE;
        for (int r = KIND_CNT - 1; r >= 0; r--) begin
            if (kind_any[kind_at_rank(3'(r))]) begin
                evt_o.code = kind_to_code(kind_at_rank(3'(r)));
            end
        end
    end

    // R3: a hit always selects a real error code
    a_r3_hit_is_error: assert property (@(posedge clk_i) disable iff (rst_i)
        evt_o.hit |-> !is_open(evt_o.code));

    // R2: no strobes means no event
    a_r2_quiet_no_hit: assert property (@(posedge clk_i) disable iff (rst_i)
        (flags_i == FLAG_W'(0)) |-> !evt_o.hit);

endmodule

// File: rtl/can_err_field_reg.sv
`timescale 1ns/1ps
module can_err_field_reg
    import can_errstat_pkg::*;
(
    input  logic      clk_i,
    input  logic      rst_i,
    input  err_evt_t  evt_i,
    input  logic      frame_clean_i,
    input  logic      rd_i,
    input  logic      swint_mode_i,
    output err_code_e code_o,
    output logic      load_o
);

    err_code_e code_q;
    logic      open_w;
    logic      err_take;
    logic      clean_take;
    logic      rd_clear;

    assign open_w     = is_open(code_q);
    assign err_take   = evt_i.hit && open_w;
    assign clean_take = frame_clean_i && (code_q == ERR_IDLE) && !evt_i.hit;
    assign rd_clear   = rd_i && !swint_mode_i;

    // Events judged on the held value win over the read clear.
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            code_q <= ERR_IDLE;
        end else if (err_take) begin
            code_q <= evt_i.code;
        end else if (clean_take) begin
            code_q <= ERR_NONE;
        end else if (rd_clear) begin
            code_q <= ERR_IDLE;
        end
    end

    assign code_o = code_q;
    assign load_o = err_take;

    // R4: a pending code survives every strobe until a clearing read
    a_r4_pending_hold: assert property (@(posedge clk_i) disable iff (rst_i)
        (!is_open(code_q) && !(rd_i && !swint_mode_i)) |=> $stable(code_q));

    // R5: plain read with nothing else pending returns to 111b
    a_r5_read_clears: assert property (@(posedge clk_i) disable iff (rst_i)
        (rd_i && !swint_mode_i && !evt_i.hit && !frame_clean_i) |=> (code_q == ERR_IDLE));

    // R5: read in software-interrupt mode keeps the code
    a_r5_swint_keeps: assert property (@(posedge clk_i) disable iff (rst_i)
        (rd_i && swint_mode_i && !evt_i.hit && !frame_clean_i) |=> $stable(code_q));

    // R6: clean frame from 111b yields 000b
    a_r6_clean_from_idle: assert property (@(posedge clk_i) disable iff (rst_i)
        (frame_clean_i && !evt_i.hit && (code_q == ERR_IDLE)) |=> (code_q == ERR_NONE));

endmodule

// File: rtl/can_txs_flag_reg.sv
`timescale 1ns/1ps
module can_txs_flag_reg (
    input  logic clk_i,
    input  logic rst_i,
    input  logic tx_ok_i,
    input  logic wr_en_i,
    input  logic wr_data_i,
    output logic flag_o,
    output logic sw_rise_o
);

    logic flag_q;

    // Hardware success overrides any software write in the same cycle.
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            flag_q <= 1'b0;
        end else if (tx_ok_i) begin
            flag_q <= 1'b1;
        end else if (wr_en_i) begin
            flag_q <= wr_data_i;
        end
    end

    assign flag_o    = flag_q;
    assign sw_rise_o = wr_en_i && wr_data_i && !flag_q;

    // R8: success always leaves the flag set
    a_r8_tx_sets: assert property (@(posedge clk_i) disable iff (rst_i)
        tx_ok_i |=> flag_o);

    // R9: write of 0 without a success clears the flag
    a_r9_wr_zero: assert property (@(posedge clk_i) disable iff (rst_i)
        (wr_en_i && !wr_data_i && !tx_ok_i) |=> !flag_o);

endmodule

// File: rtl/can_stat_irq.sv
`timescale 1ns/1ps
module can_stat_irq (
    input  logic clk_i,
    input  logic rst_i,
    input  logic err_load_i,
    input  logic err_ie_i,
    input  logic tx_ok_i,
    input  logic sw_rise_i,
    input  logic stat_ie_i,
    input  logic rd_i,
    output logic irq_o
);

    logic irq_q;
    logic set_w;

    assign set_w = (err_load_i && err_ie_i) || ((tx_ok_i || sw_rise_i) && stat_ie_i);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            irq_q <= 1'b0;
        end else if (set_w) begin
            irq_q <= 1'b1;
        end else if (rd_i) begin
            irq_q <= 1'b0;
        end
    end

    assign irq_o = irq_q;

    // R7: an enabled recorded error raises the request
    a_r7_err_raises: assert property (@(posedge clk_i) disable iff (rst_i)
        (err_load_i && err_ie_i) |=> irq_o);

    // R10: request persists without a read
    a_r10_sticky: assert property (@(posedge clk_i) disable iff (rst_i)
        (irq_o && !rd_i) |=> irq_o);

    // R10: read with no source drops the request
    a_r10_read_drops: assert property (@(posedge clk_i) disable iff (rst_i)
        (rd_i && !err_load_i && !tx_ok_i && !sw_rise_i) |=> !irq_o);

endmodule

// File: rtl/can_errstat_latch.sv
`timescale 1ns/1ps
module can_errstat_latch
    import can_errstat_pkg::*;
#(
    parameter int NUM_CTR = 3
) (
    input  logic                        clk_i,
    input  logic                        rst_i,
    input  logic [NUM_CTR*KIND_CNT-1:0] err_flags_i,
    input  logic                        frame_clean_i,
    input  logic                        tx_ok_i,
    input  logic                        stat_rd_i,
    input  logic                        swint_mode_i,
    input  logic                        txs_wr_en_i,
    input  logic                        txs_wr_data_i,
    input  logic                        err_ie_i,
    input  logic                        stat_ie_i,
    output logic [2:0]                  err_code_o,
    output logic                        txs_o,
    output logic                        irq_o
);

    err_evt_t  evt;
    err_code_e code;
    logic      err_load;
    logic      sw_rise;

    can_err_prio_sel #(.NUM_CTR(NUM_CTR)) u_sel (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .flags_i (err_flags_i),
        .evt_o   (evt)
    );

    can_err_field_reg u_field (
        .clk_i         (clk_i),
        .rst_i         (rst_i),
        .evt_i         (evt),
        .frame_clean_i (frame_clean_i),
        .rd_i          (stat_rd_i),
        .swint_mode_i  (swint_mode_i),
        .code_o        (code),
        .load_o        (err_load)
    );

    can_txs_flag_reg u_txs (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .tx_ok_i   (tx_ok_i),
        .wr_en_i   (txs_wr_en_i),
        .wr_data_i (txs_wr_data_i),
        .flag_o    (txs_o),
        .sw_rise_o (sw_rise)
    );

    can_stat_irq u_irq (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .err_load_i (err_load),
        .err_ie_i   (err_ie_i),
        .tx_ok_i    (tx_ok_i),
        .sw_rise_i  (sw_rise),
        .stat_ie_i  (stat_ie_i),
        .rd_i       (stat_rd_i),
        .irq_o      (irq_o)
    );

    assign err_code_o = code;

    // R9: rewriting 1 over a set flag stays silent
    a_r9_redundant_write: assert property (@(posedge clk_i) disable iff (rst_i)
        (!irq_o && txs_o && txs_wr_en_i && txs_wr_data_i && !tx_ok_i && !err_load)
        |=> !irq_o);

endmodule

// File: tb/can_errstat_latch_tb.sv
`timescale 1ns/1ps
module can_errstat_latch_tb_top;

    localparam int NCTR = 3;
    localparam int FW   = NCTR * 6;

    typedef struct packed {
        logic [FW-1:0] flags;
        logic          frm;
        logic          tx;
        logic          rd;
        logic          sw;
        logic          we;
        logic          wd;
        logic          eie;
        logic          sie;
        logic [2:0]    ecode;
        logic          etx;
        logic          eirq;
        logic [7:0]    req;
    } vec_t;

    localparam int NVEC = 32;

    // flags, frm, tx, rd, sw, we, wd, eie, sie, code, txs, irq, requirement
    localparam vec_t VECS [NVEC] = '{
        '{18'h00000, 0,0,0,0,0,0,1,1, 3'b111,0,0, 1 },  // R1 idle
        '{18'h00001, 0,0,0,0,0,0,1,1, 3'b001,0,1, 2 },  // R2 stuff c0
        '{18'h00800, 0,0,0,0,0,0,1,1, 3'b001,0,1, 4 },  // R4 CRC c1 dropped
        '{18'h00000, 0,0,1,0,0,0,1,1, 3'b111,0,0, 5 },  // R5 read
        '{18'h04202, 0,0,0,0,0,0,1,1, 3'b011,0,1, 3 },  // R3 noack>format>bit1
        '{18'h00000, 0,0,1,0,0,0,1,1, 3'b111,0,0, 5 },  // R5
        '{18'h00000, 1,0,0,0,0,0,1,1, 3'b000,0,0, 6 },  // R6 clean from 111
        '{18'h08020, 0,0,0,0,0,0,1,1, 3'b110,0,1, 3 },  // R3 CRC>bit1 from 000
        '{18'h00000, 1,0,0,0,0,0,1,1, 3'b110,0,1, 6 },  // R6 clean over pending
        '{18'h00000, 0,0,1,1,0,0,1,1, 3'b110,0,0, 5 },  // R5 swint keeps
        '{18'h00000, 0,0,1,0,0,0,1,1, 3'b111,0,0, 5 },  // R5
        '{18'h00401, 0,0,0,0,0,0,0,1, 3'b101,0,0, 7 },  // R7 masked, bit0>stuff
        '{18'h00000, 0,0,1,0,0,0,0,1, 3'b111,0,0, 5 },  // R5
        '{18'h3F000, 0,0,0,0,0,0,1,1, 3'b101,0,1, 3 },  // R3 all kinds c2
        '{18'h00000, 0,0,1,0,0,0,1,1, 3'b111,0,0, 10},  // R10 read clears
        '{18'h00000, 0,1,0,0,0,0,1,1, 3'b111,1,1, 8 },  // R8 tx ok
        '{18'h00000, 0,0,1,0,0,0,1,1, 3'b111,1,0, 10},  // R10
        '{18'h00000, 0,1,0,0,0,0,1,1, 3'b111,1,1, 8 },  // R8 flag already 1
        '{18'h00000, 0,1,1,0,0,0,1,1, 3'b111,1,1, 10},  // R10 set beats clear
        '{18'h00000, 0,0,1,0,0,0,1,1, 3'b111,1,0, 10},  // R10
        '{18'h00000, 0,0,0,0,1,1,1,1, 3'b111,1,0, 9 },  // R9 redundant write
        '{18'h00000, 0,0,0,0,1,0,1,1, 3'b111,0,0, 9 },  // R9 write 0
        '{18'h00000, 0,0,0,0,1,1,1,1, 3'b111,1,1, 9 },  // R9 write 0->1
        '{18'h00000, 0,0,1,0,0,0,1,1, 3'b111,1,0, 10},  // R10
        '{18'h00000, 0,1,0,0,1,0,1,1, 3'b111,1,1, 9 },  // R9 tx beats write 0
        '{18'h00000, 0,0,1,0,0,0,1,1, 3'b111,1,0, 10},  // R10
        '{18'h00002, 0,0,1,0,0,0,1,1, 3'b010,1,1, 11},  // R11 error beats read
        '{18'h00001, 0,0,1,0,0,0,1,1, 3'b111,1,0, 11},  // R11 pending, read clears
        '{18'h00000, 1,0,1,0,0,0,1,1, 3'b000,1,0, 11},  // R11 clean beats read
        '{18'h00000, 0,1,0,0,0,0,1,0, 3'b000,1,0, 8 },  // R8 masked
        '{18'h00000, 1,0,0,0,0,0,1,1, 3'b000,1,0, 6 },  // R6 clean from 000
        '{18'h00100, 0,0,1,0,0,0,1,1, 3'b011,1,1, 11}   // R11 error from 000
    };

    logic          clk = 1'b0;
    logic          rst;
    logic [FW-1:0] err_flags;
    logic          frame_clean, tx_ok, stat_rd, swint_mode;
    logic          txs_wr_en, txs_wr_data, err_ie, stat_ie;
    logic [2:0]    err_code;
    logic          txs, irq;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    can_errstat_latch #(.NUM_CTR(NCTR)) dut_i (
        .clk_i         (clk),
        .rst_i         (rst),
        .err_flags_i   (err_flags),
        .frame_clean_i (frame_clean),
        .tx_ok_i       (tx_ok),
        .stat_rd_i     (stat_rd),
        .swint_mode_i  (swint_mode),
        .txs_wr_en_i   (txs_wr_en),
        .txs_wr_data_i (txs_wr_data),
        .err_ie_i      (err_ie),
        .stat_ie_i     (stat_ie),
        .err_code_o    (err_code),
        .txs_o         (txs),
        .irq_o         (irq)
    );

    task automatic check(input int req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL R%0d %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        err_flags   = v.flags;
        frame_clean = v.frm;
        tx_ok       = v.tx;
        stat_rd     = v.rd;
        swint_mode  = v.sw;
        txs_wr_en   = v.we;
        txs_wr_data = v.wd;
        err_ie      = v.eie;
        stat_ie     = v.sie;
        @(negedge clk);
    endtask

    task automatic quiet();
        err_flags = '0; frame_clean = 0; tx_ok = 0; stat_rd = 0; swint_mode = 0;
        txs_wr_en = 0; txs_wr_data = 0; err_ie = 1; stat_ie = 1;
    endtask

    initial begin
        quiet();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        // R1: state during reset
        check(1, "reset code", int'(err_code), 7);
        check(1, "reset txs", int'(txs), 0);
        check(1, "reset irq", int'(irq), 0);
        rst = 1'b0;

        for (int i = 0; i < NVEC; i++) begin
            drive(VECS[i]);
            check(int'(VECS[i].req), $sformatf("vec %0d code", i), int'(err_code), int'(VECS[i].ecode));
            check(int'(VECS[i].req), $sformatf("vec %0d txs", i), int'(txs), int'(VECS[i].etx));
            check(int'(VECS[i].req), $sformatf("vec %0d irq", i), int'(irq), int'(VECS[i].eirq));
        end

        // R1: reset in mid-run with code 011, flag and request set
        quiet();
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check(1, "midrun reset code", int'(err_code), 7);
        check(1, "midrun reset txs", int'(txs), 0);
        check(1, "midrun reset irq", int'(irq), 0);

        // R9: software 0->1 with status interrupts masked raises nothing
        quiet();
        stat_ie = 0; txs_wr_en = 1; txs_wr_data = 1;
        @(negedge clk);
        quiet();
        check(9, "masked write txs", int'(txs), 1);
        check(9, "masked write irq", int'(irq), 0);

        // R4: pending code shields it from a higher-ranked error, no irq
        err_flags = 18'h00001; @(negedge clk); quiet();
        stat_rd = 1; @(negedge clk); quiet();
        err_flags = 18'h00008; @(negedge clk); quiet();       // bit-1 from 111
        check(2, "bit1 code", int'(err_code), 4);
        stat_rd = 1; swint_mode = 1; @(negedge clk); quiet(); // drop irq, keep code
        err_flags = 18'h00010; @(negedge clk); quiet();       // bit-0 discarded
        check(4, "held under bit0", int'(err_code), 4);
        check(4, "no irq when dropped", int'(irq), 0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(5.0 * 20000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule